// File: doc/BRIEF.md
# Block-Type-Adaptive 8x8 DCT Engine

This block turns a stream of 8x8 pixel blocks into 8x8 sets of DCT-II coefficients. It works row by row and then column by column. One bank of eight parallel multipliers forms each row coefficient, and the results go into an intermediate store. A second bank then forms each final coefficient from one column of that store. Every block comes with a one-bit type flag on the same beat as its first pixel. The engine never works out the type itself.

A detailed block goes through the full datapath. The level shift subtracts 128 from each pixel, and all eight multiplier lanes are used.

A background block is handled at 2x2 resolution:
- The first pixel of the block is subtracted from every pixel, so only differences enter the datapath.
- Only every second row is transformed. The result of each such row is written into the row below it as well.
- In both passes, each pair of neighbouring inputs is folded into one lane, so half of the lanes are idle.
- After the column pass, the removed offset is added back into the DC coefficient.

The control is a three-state machine:
- **LOAD** collects 64 pixels. The transition *block_full* leads to ROW_PASS.
- **ROW_PASS** forms the row coefficients. It takes 64 cycles for a detailed block and 32 for a background block. The transition *rows_done* leads to COL_PASS.
- **COL_PASS** forms and emits one output coefficient per cycle. The transition *coefs_done* returns to LOAD.

Top module: `bta_dct8x8`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: `in_ready` stays high while a block is being collected and drops in the cycle after the 64th pixel is accepted. A pixel is taken on a clock edge where `in_valid` and `in_ready` are both high, in row-major order (index = row*8 + column).
- R3: The block type is sampled together with the first pixel of the block (1 = background, 0 = detailed). The value of `in_bg` on the other 63 pixels has no effect.
- R4: Pixels are 8-bit unsigned. For a detailed block, each output is within ±1 of the orthonormal 2D DCT-II of (pixel − 128). Outputs are given as 12-bit two's complement.
- R5: A background block produces, within ±1, the transform of the block in which every pixel is replaced by the top-left pixel of its aligned 2x2 group. The other three pixels of each group have no effect.
- R6: For a background block, the first pixel's offset is restored into the DC term. A uniform background block of value p gives DC = 8·(p − 128) and zero AC terms, within ±1.
- R7: Each block yields 64 coefficients on 64 consecutive `out_valid` cycles, in row-major order (index = u*8 + v, where u is the vertical frequency and v the horizontal frequency). `out_last` is high only on the 64th coefficient, and `out_valid` is low in the cycle after it.
- R8: The first coefficient appears 65 clock edges after the edge that accepts the last pixel of a detailed block, and 33 edges after it for a background block.
- R9: While `out_last` is shown, `in_ready` is already high, so the first pixel of the next block can be taken on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is present on `in_pix` |
| in_ready | output | 1 | The engine is collecting pixels |
| in_pix | input | 8 | Unsigned pixel value |
| in_bg | input | 1 | Block type, read with the first pixel: 1 = background |
| out_valid | output | 1 | `out_coef` holds a coefficient |
| out_coef | output | 12 | Signed coefficient |
| out_last | output | 1 | Marks the 64th coefficient of a block |

## Verification
The last coefficient of one block leaves the engine in the same cycle in which the next block's first pixel, with its type flag, can be accepted. This is because the machine re-enters LOAD on the same edge that registers `out_last`. The bench provokes this overlap by sending blocks back to back, alternating between types. Its driver presents the next first pixel as soon as `in_ready` is seen. The monitor checks that `in_ready` is high whenever `out_last` is seen. The overlap is judged correct when the next block's coefficients, DC correction and latency all match a block that started from idle. That shows the freshly latched type and reference pixel were not disturbed by the tail of the previous block.

// File: rtl/bta_dct_pkg.sv
package bta_dct_pkg;

    localparam int COEF_W    = 14;
    localparam int COEF_FRAC = 12;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_ROW,
        ST_COL
    } seq_state_e;

    // 2048 * cos(m * pi / 16), folded into the first quadrant
    function automatic logic signed [COEF_W-1:0] cos_q(input int unsigned m);
        int unsigned a;
        logic neg;
        logic signed [COEF_W-1:0] mag;
        a   = m % 32;
        if (a > 16) a = 32 - a;
        neg = 1'b0;
        if (a > 8) begin
            a   = 16 - a;
            neg = 1'b1;
        end
        case (a)
            0:       mag = 14'sd2048;
            1:       mag = 14'sd2009;
            2:       mag = 14'sd1892;
            3:       mag = 14'sd1703;
            4:       mag = 14'sd1448;
            5:       mag = 14'sd1138;
            6:       mag = 14'sd784;
            7:       mag = 14'sd400;
            default: mag = 14'sd0;
        endcase
        return neg ? -mag : mag;
    endfunction

    // orthonormal 8-point basis weight, scaled by 2^COEF_FRAC
    function automatic logic signed [COEF_W-1:0] basis(input int unsigned k, input int unsigned n);
        if (k == 0) return 14'sd1448;
        return cos_q((2 * n + 1) * k);
    endfunction

endpackage

// File: rtl/bta_dct_mac8.sv
module bta_dct_mac8 import bta_dct_pkg::*; #(
    parameter int IN_W  = 9,
    parameter int LANES = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic signed [IN_W-1:0]                      vec_i [LANES],
    input  logic [$clog2(LANES)-1:0]                    freq_i,
    input  logic                                        half_i,
    output logic signed [IN_W+COEF_W+$clog2(LANES)-1:0] acc_o
);

    localparam int SEL_W = $clog2(LANES);
    localparam int PR_W  = IN_W + COEF_W;
    localparam int ACC_W = PR_W + SEL_W;

    logic signed [PR_W-1:0] prod [LANES];

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic signed [COEF_W-1:0] w;
        logic signed [IN_W-1:0]   xin;
        if (n % 2 == 0) begin : g_even
            // in half mode this lane carries its odd neighbour's weight too
            always_comb begin
                if (half_i)
                    w = basis(32'(freq_i), n) + basis(32'(freq_i), n + 1);
                else
                    w = basis(32'(freq_i), n);
            end
            assign xin = vec_i[n];
        end else begin : g_odd
            always_comb w = basis(32'(freq_i), n);
            assign xin = half_i ? '0 : vec_i[n];

            a_r5_odd_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
                half_i |-> (prod[n] == '0));
        end
        assign prod[n] = xin * w;
    end

    always_comb begin
        acc_o = '0;
        for (int n = 0; n < LANES; n++)
            acc_o = acc_o + ACC_W'(prod[n]);
    end

endmodule

// File: rtl/bta_dct_seq.sv
module bta_dct_seq import bta_dct_pkg::*; #(
    parameter int NPIX = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid_i,
    input  logic                            bg_i,
    output seq_state_e                      state_o,
    output logic [$clog2(NPIX*NPIX)-1:0]    idx_o,
    output logic                            ready_o,
    output logic                            row_en_o,
    output logic                            col_en_o
);

    localparam int NN    = NPIX * NPIX;
    localparam int IDX_W = $clog2(NN);
    localparam int RC_W  = $clog2(NPIX);
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(NN - 1);
    localparam logic [IDX_W-1:0] BG_LAST  = IDX_W'(NN - 1 - NPIX);
    localparam logic [RC_W-1:0]  K_LAST   = RC_W'(NPIX - 1);

    seq_state_e             state_q, state_d;
    logic [IDX_W-1:0]       idx_q, idx_d;
    logic                   rows_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions: block_full, rows_done, coefs_done
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        rows_done = (idx_q == LAST) || (bg_i && idx_q == BG_LAST);
        unique case (state_q)
            ST_LOAD: begin
                if (in_valid_i) begin
                    if (idx_q == LAST) begin
                        state_d = ST_ROW;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_ROW: begin
                if (rows_done) begin
                    state_d = ST_COL;
                    idx_d   = '0;
                end else if (bg_i && idx_q[RC_W-1:0] == K_LAST) begin
                    idx_d = idx_q + IDX_W'(NPIX + 1);
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_COL: begin
                if (idx_q == LAST) begin
                    state_d = ST_LOAD;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_LOAD;
                idx_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready_o  = 1'b0;
        row_en_o = 1'b0;
        col_en_o = 1'b0;
        unique case (state_q)
            ST_LOAD: ready_o  = 1'b1;
            ST_ROW:  row_en_o = 1'b1;
            ST_COL:  col_en_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(in_valid_i));

    a_r8_even_rows_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW && bg_i) |-> !idx_q[RC_W]);

endmodule

// File: rtl/bta_dct8x8.sv
module bta_dct8x8 import bta_dct_pkg::*; #(
    parameter int NPIX     = 8,
    parameter int PIX_W    = 8,
    parameter int OUT_W    = 12,
    parameter int MID_W    = 16,
    parameter int MID_FRAC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_bg,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_coef,
    output logic              out_last
);

    localparam int NN        = NPIX * NPIX;
    localparam int IDX_W     = $clog2(NN);
    localparam int RC_W      = $clog2(NPIX);
    localparam int DIF_W     = PIX_W + 1;
    localparam int LVL       = 1 << (PIX_W - 1);
    localparam int ROW_ACC_W = DIF_W + COEF_W + RC_W;
    localparam int COL_ACC_W = MID_W + COEF_W + RC_W;
    localparam int ROW_SH    = COEF_FRAC - MID_FRAC;
    localparam int COL_SH    = COEF_FRAC + MID_FRAC;
    localparam int ROW_HALF  = 1 << (ROW_SH - 1);
    localparam int COL_HALF  = 1 << (COL_SH - 1);

    seq_state_e           st;
    logic [IDX_W-1:0]     idx;
    logic                 row_en, col_en, take, first;

    logic                 bg_q;
    logic [PIX_W-1:0]     ref_q;
    logic                 cur_bg;
    logic [PIX_W-1:0]     cur_ref;
    logic [DIF_W-1:0]     diff;

    logic signed [DIF_W-1:0] pix_q [NN];
    logic signed [MID_W-1:0] tmp_q [NN];

    logic signed [DIF_W-1:0]     row_vec [NPIX];
    logic signed [MID_W-1:0]     col_vec [NPIX];
    logic signed [ROW_ACC_W-1:0] row_acc, row_rnd, row_scl;
    logic signed [COL_ACC_W-1:0] col_acc, col_rnd, col_scl, dc_fix, coef_sum;
    logic signed [MID_W-1:0]     mid;
    logic [DIF_W-1:0]            ref_lvl;

    bta_dct_seq #(.NPIX(NPIX)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .bg_i       (bg_q),
        .state_o    (st),
        .idx_o      (idx),
        .ready_o    (in_ready),
        .row_en_o   (row_en),
        .col_en_o   (col_en)
    );

    // ---------------- input stage: level shift or reference difference
    assign take  = in_valid && in_ready;
    assign first = (idx == '0);

    always_comb begin
        cur_bg  = first ? in_bg  : bg_q;
        cur_ref = first ? in_pix : ref_q;
        if (cur_bg)
            diff = {1'b0, in_pix} - {1'b0, cur_ref};
        else
            diff = {1'b0, in_pix} - DIF_W'(LVL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q  <= 1'b0;
            ref_q <= '0;
        end else if (take && first) begin
            bg_q  <= in_bg;
            ref_q <= in_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (take) pix_q[idx] <= diff;
    end

    // ---------------- row pass
    always_comb begin
        for (int n = 0; n < NPIX; n++)
            row_vec[n] = pix_q[{idx[IDX_W-1:RC_W], RC_W'(n)}];
    end

    bta_dct_mac8 #(.IN_W(DIF_W), .LANES(NPIX)) i_row_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (row_vec),
        .freq_i (idx[RC_W-1:0]),
        .half_i (bg_q),
        .acc_o  (row_acc)
    );

    assign row_rnd = row_acc + ROW_ACC_W'(ROW_HALF);
    assign row_scl = row_rnd >>> ROW_SH;
    assign mid     = row_scl[MID_W-1:0];

    always_ff @(posedge clk) begin
        if (row_en) begin
            tmp_q[idx] <= mid;
            if (bg_q) tmp_q[idx + IDX_W'(NPIX)] <= mid;
        end
    end

    // ---------------- column pass and DC repair
    always_comb begin
        for (int n = 0; n < NPIX; n++)
            col_vec[n] = tmp_q[{RC_W'(n), idx[RC_W-1:0]}];
    end

    bta_dct_mac8 #(.IN_W(MID_W), .LANES(NPIX)) i_col_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (col_vec),
        .freq_i (idx[IDX_W-1:RC_W]),
        .half_i (bg_q),
        .acc_o  (col_acc)
    );

    assign col_rnd = col_acc + COL_ACC_W'(COL_HALF);
    assign col_scl = col_rnd >>> COL_SH;
    assign ref_lvl = {1'b0, ref_q} - DIF_W'(LVL);

    always_comb begin
        if (bg_q && first)
            dc_fix = {{(COL_ACC_W-DIF_W){ref_lvl[DIF_W-1]}}, ref_lvl} << RC_W;
        else
            dc_fix = '0;
        coef_sum = col_scl + dc_fix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_coef  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= col_en;
            out_coef  <= coef_sum[OUT_W-1:0];
            out_last  <= col_en && (idx == IDX_W'(NN - 1));
        end
    end

    a_r7_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    a_r5_row_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (col_en && bg_q) |->
        (tmp_q[IDX_W'(NPIX) + IDX_W'(idx[RC_W-1:0])] == tmp_q[IDX_W'(idx[RC_W-1:0])]));

endmodule

// File: tb/test_bta_dct8x8.sv
module test_bta_dct8x8;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_pix = '0;
    logic        in_bg = 1'b0;
    logic        out_valid;
    logic [11:0] out_coef;
    logic        out_last;

    int total = 0;
    int bad   = 0;
    int mcount = 0;
    bit finished = 1'b0;

    real   exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bta_dct8x8 i_bta_dct8x8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .in_bg     (in_bg),
        .out_valid (out_valid),
        .out_coef  (out_coef),
        .out_last  (out_last)
    );

    function automatic real cb(int k, int n);
        real s;
        s = (k == 0) ? $sqrt(0.125) : 0.5;
        return s * $cos((2 * n + 1) * k * 3.14159265358979 / 16.0);
    endfunction

    task automatic check_int(string req, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // driver: push the expected coefficients, then stream the pixels
    task automatic send_block(input int pix[64], input bit bg, input bit noisy_flag, input string tag);
        real x[64];
        real s;
        int  cnt;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int src;
                src = bg ? ((r / 2) * 16 + (c / 2) * 2) : (r * 8 + c);
                x[r * 8 + c] = real'(pix[src] - 128);
            end
        for (int u = 0; u < 8; u++)
            for (int v = 0; v < 8; v++) begin
                s = 0.0;
                for (int r = 0; r < 8; r++)
                    for (int c = 0; c < 8; c++)
                        s += x[r * 8 + c] * cb(u, r) * cb(v, c);
                exp_q.push_back(s);
                tag_q.push_back(tag);
            end
        for (int i = 0; i < 64; i++) begin
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_pix   = pix[i][7:0];
            in_bg    = (i == 0) ? bg : (noisy_flag ? ~bg : bg);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_bg    = 1'b0;
        // R2: collection closed after the 64th pixel
        check_int("R2", "in_ready after last pixel", int'(in_ready), 0);
        cnt = 0;
        while (!out_valid && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        // R8: row pass length depends on the block type
        check_int("R8", bg ? "background latency" : "detailed latency", cnt, bg ? 33 : 65);
    endtask

    // monitor: compare each coefficient as it leaves
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R7 unexpected coefficient: got %0d expected none", $signed(out_coef));
            end else begin
                real   e;
                real   d;
                string t;
                int    act;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                act = int'($signed(out_coef));
                d   = real'(act) - e;
                total++;
                if (d > 1.0 || d < -1.0) begin
                    bad++;
                    $display("FAIL %s coef %0d: got %0d expected %f", t, mcount % 64, act, e);
                end
                check_int("R7", "last marker", int'(out_last), (mcount % 64 == 63) ? 1 : 0);
                if (out_last)
                    check_int("R9", "ready while last shown", int'(in_ready), 1);
                mcount++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R7 watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int blk[64];
        int guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_int("R1", "out_valid after reset", int'(out_valid), 0);
        check_int("R1", "out_last after reset", int'(out_last), 0);
        check_int("R1", "in_ready after reset", int'(in_ready), 1);

        // R4: detailed, random pixels
        for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
        send_block(blk, 1'b0, 1'b0, "R4");
        // R4: detailed, uniform 200
        for (int i = 0; i < 64; i++) blk[i] = 200;
        send_block(blk, 1'b0, 1'b0, "R4");
        // R4: detailed, checkerboard extremes
        for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 0 : 255;
        send_block(blk, 1'b0, 1'b0, "R4");
        // R5: background with true 2x2 structure
        for (int i = 0; i < 64; i++) blk[i] = 90 + 5 * ((i / 16) + ((i % 8) / 2));
        send_block(blk, 1'b1, 1'b0, "R5");
        // R5: background with noisy non-representative pixels (must be ignored)
        for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
        send_block(blk, 1'b1, 1'b0, "R5");
        // R6: uniform background at the top of the range
        for (int i = 0; i < 64; i++) blk[i] = 255;
        send_block(blk, 1'b1, 1'b0, "R6");
        // R6: first pixel dark, rest bright: widest difference
        for (int i = 0; i < 64; i++) blk[i] = 255;
        blk[0] = 0;
        send_block(blk, 1'b1, 1'b0, "R6");
        // R6: uniform background at zero
        for (int i = 0; i < 64; i++) blk[i] = 0;
        send_block(blk, 1'b1, 1'b0, "R6");
        // R3: flag toggled after the first pixel, both types
        for (int i = 0; i < 64; i++) blk[i] = $urandom_range(20, 235);
        send_block(blk, 1'b0, 1'b1, "R3");
        for (int i = 0; i < 64; i++) blk[i] = $urandom_range(20, 235);
        send_block(blk, 1'b1, 1'b1, "R3");
        // R9: back-to-back alternating types
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
            send_block(blk, b[0], 1'b0, "R9");
        end

        guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check_int("R7", "coefficients left undelivered", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule